// File: doc/BRIEF.md
# Serial Audio Reframing Port

This block receives a two-channel PCM stream on a bit clock, a word-select (LR) clock and one serial data line, and sends the same samples out again on its own serial data line. The input side accepts three slot conventions: I2S, left-justified and right-justified. Every frame is 64 bit clocks long and holds two 32-clock slots. The input word length is 16, 20 or 24 bits. Each captured stereo pair also appears on two parallel sample buses, with a one-cycle strobe.

The output side shares the incoming bit clock and LR clock. It uses its own word length and, when reframing is enabled, its own slot convention. This lets a stream that arrives in one justification style leave in another, for example left-justified in and I2S out. When reframing is off, the output keeps the input's slot convention and changes only the word length. All logic runs in the bit-clock domain. Input data is sampled on the rising edge and output data is launched on the falling edge.

Top module: `sap_reframer`

## Requirements
- R1: While reset is asserted and right after it is released, `smp_valid`, `sdout`, `left_smp` and `right_smp` are all zero.
- R2: Input format code 0 (I2S): LR clock low marks the left slot. The sample MSB is on the second rising bit clock after an LR transition (slot position 1). The following word bits come on consecutive clocks, MSB first.
- R3: Input format code 1 (left-justified): LR clock high marks the left slot. The MSB is on the first rising bit clock of the slot (position 0).
- R4: Input format code 2 (right-justified): LR clock high marks the left slot. The LSB is on the last bit clock of the slot (position 31). Earlier slot bits are ignored.
- R5: Size code 0/1/2 selects 16/20/24-bit words (code 3 acts as 24). A captured word is placed MSB-aligned on the 24-bit sample buses, and the unused low bits read zero.
- R6: `smp_valid` is high for exactly one bit clock, starting at the rising edge that captures the right-channel LSB. At that moment both buses carry the left and right words of the same frame. This happens once per frame.
- R7: Until the first LR clock transition after reset, nothing is captured: `smp_valid` stays low and `sdout` stays low.
- R8: With `norm_en` = 1, the output slots follow `out_fmt`, using the same codes, channel polarity and bit positions as R2–R4. Bits outside the word window are driven low.
- R9: With `norm_en` = 0, the output slots follow `in_fmt`, whatever the value of `out_fmt`.
- R10: The output word length follows `out_size`, using the codes of R5. A shorter output word keeps the top bits of the captured sample and drops the LSB end. A longer output word is padded with trailing zeros.
- R11: With a steady 64-clock frame, consecutive output left/right slot pairs carry the captured pairs in capture order. Both halves of a pair come from one frame, and no frame is skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; input sampled on rising, output launched on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Word-select clock, one level per 32-clock slot |
| sdin | input | 1 | Serial data in, MSB first |
| in_fmt | input | 2 | Input slot convention: 0 I2S, 1 left-justified, 2 right-justified |
| in_size | input | 2 | Input word length code (0:16, 1:20, 2:24) |
| out_fmt | input | 2 | Output slot convention when reframing is enabled |
| out_size | input | 2 | Output word length code |
| norm_en | input | 1 | 1: output uses out_fmt; 0: output reuses in_fmt |
| sdout | output | 1 | Serial data out |
| left_smp | output | 24 | Last captured left sample, MSB-aligned |
| right_smp | output | 24 | Last captured right sample, MSB-aligned |
| smp_valid | output | 1 | One-cycle strobe per captured pair |

## Verification
The assertions assume a well-formed frame once the port has locked: each LR level must last exactly 32 bit clocks. They also assume the configuration inputs stay constant while a stream is running. The bench changes configuration only while reset is held. It releases reset with one idle slot at the right-channel level, then drives whole 64-clock frames with no gaps. Every scenario therefore locks on a clean left-slot boundary and never breaks the slot length.

// File: rtl/sap_pkg.sv
package sap_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2
  } sap_fmt_e;

  // word length in bits for a size code
  function automatic int word_len(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      default: return 24;
    endcase
  endfunction

  // LR level that marks the left slot
  function automatic logic left_level(input logic [1:0] fmt);
    return (fmt != FMT_I2S);
  endfunction

  // slot position of the first word bit
  function automatic int win_start(input logic [1:0] fmt, input int n, input int slot);
    case (fmt)
      FMT_I2S: return 1;
      FMT_RJ:  return slot - n;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sap_rx.sv
module sap_rx
  import sap_pkg::*;
#(
  parameter int SMP_W     = 24,
  parameter int SLOT_BITS = 32,
  localparam int POS_W    = $clog2(SLOT_BITS)
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             lrck,
  input  logic             sdin,
  input  logic [1:0]       fmt,
  input  logic [1:0]       size,
  output logic             lock,
  output logic [POS_W-1:0] pos,
  output logic             lvl,
  output logic [SMP_W-1:0] left_o,
  output logic [SMP_W-1:0] right_o,
  output logic             valid
);

  logic             seen, seen_n, lock_n, lvl_n, valid_n;
  logic [POS_W-1:0] pos_n, pos_cur;
  logic [SMP_W-1:0] acc, acc_n, hold, hold_n, left_n, right_n, word;
  logic             lr_edge, run, in_win, is_left;
  int               n, st, p;

  always_comb begin
    lr_edge = seen & (lrck ^ lvl);
    pos_cur = lr_edge ? '0 : pos + 1'b1;
    run     = lock | lr_edge;
    n       = word_len(size);
    st      = win_start(fmt, n, SLOT_BITS);
    p       = int'(pos_cur);
    in_win  = run && (p >= st) && (p < st + n);
    is_left = (lrck == left_level(fmt));

    seen_n  = 1'b1;
    lvl_n   = lrck;
    lock_n  = run;
    pos_n   = run ? pos_cur : pos;
    acc_n   = acc;
    hold_n  = hold;
    left_n  = left_o;
    right_n = right_o;
    valid_n = 1'b0;
    word    = '0;
    if (in_win) begin
      acc_n = (p == st) ? SMP_W'(sdin) : {acc[SMP_W-2:0], sdin};
      if (p == st + n - 1) begin
        word = acc_n << (SMP_W - n);
        if (is_left) begin
          hold_n = word;
        end else begin
          left_n  = hold;
          right_n = word;
          valid_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      lvl     <= 1'b0;
      lock    <= 1'b0;
      pos     <= '0;
      acc     <= '0;
      hold    <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid   <= 1'b0;
    end else begin
      seen    <= seen_n;
      lvl     <= lvl_n;
      lock    <= lock_n;
      pos     <= pos_n;
      acc     <= acc_n;
      hold    <= hold_n;
      left_o  <= left_n;
      right_o <= right_n;
      valid   <= valid_n;
    end
  end

  // R6: strobe never lasts two clocks
  p_valid_single_r6: assert property (@(posedge bclk) disable iff (!rst_n)
    valid |=> !valid);

  // R11: once locked, LR transitions arrive exactly one slot apart
  p_slot_len_r11: assert property (@(posedge bclk) disable iff (!rst_n)
    (lock && seen && (lrck != lvl)) |-> (pos == POS_W'(SLOT_BITS - 1)));

  // R5: a 16-bit capture leaves the low bits of both buses clear
  p_lsb_zero_r5: assert property (@(posedge bclk) disable iff (!rst_n)
    (valid && $past(size) == 2'd0) |->
      (left_o[SMP_W-17:0] == '0 && right_o[SMP_W-17:0] == '0));

endmodule

// File: rtl/sap_tx.sv
module sap_tx
  import sap_pkg::*;
#(
  parameter int SMP_W     = 24,
  parameter int SLOT_BITS = 32,
  localparam int POS_W    = $clog2(SLOT_BITS)
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic [POS_W-1:0] pos,
  input  logic             lvl,
  input  logic [SMP_W-1:0] left_i,
  input  logic [SMP_W-1:0] right_i,
  input  logic [1:0]       in_fmt,
  input  logic [1:0]       out_fmt,
  input  logic [1:0]       out_size,
  input  logic             norm_en,
  output logic             sdout
);

  logic [SMP_W-1:0] tx_l, tx_r, tx_l_n, tx_r_n, src, shw;
  logic [POS_W-1:0] np;
  logic [1:0]       eff;
  logic             wrap, nlv, is_left, latch, in_win, bit_n;
  int               n, st, p, sa;

  always_comb begin
    eff     = norm_en ? out_fmt : in_fmt;
    wrap    = (pos == POS_W'(SLOT_BITS - 1));
    np      = wrap ? '0 : pos + 1'b1;
    nlv     = wrap ? ~lvl : lvl;
    is_left = (nlv == left_level(eff));
    n       = word_len(out_size);
    st      = win_start(eff, n, SLOT_BITS);
    p       = int'(np);
    in_win  = lock && (p >= st) && (p < st + n);
    latch   = lock && is_left && (np == '0);
    tx_l_n  = latch ? left_i  : tx_l;
    tx_r_n  = latch ? right_i : tx_r;
    src     = is_left ? tx_l_n : tx_r_n;
    sa      = in_win ? (p - st) : 0;
    shw     = src << sa;
    bit_n   = in_win & shw[SMP_W-1];
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      tx_l  <= '0;
      tx_r  <= '0;
      sdout <= 1'b0;
    end else begin
      tx_l  <= tx_l_n;
      tx_r  <= tx_r_n;
      sdout <= bit_n;
    end
  end

  // R7: the line stays quiet until the receiver has locked
  p_quiet_unlocked_r7: assert property (@(posedge bclk) disable iff (!rst_n)
    !lock |-> !sdout);

endmodule

// File: rtl/sap_reframer.sv
module sap_reframer
  import sap_pkg::*;
#(
  parameter int SMP_W     = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             lrck,
  input  logic             sdin,
  input  logic [1:0]       in_fmt,
  input  logic [1:0]       in_size,
  input  logic [1:0]       out_fmt,
  input  logic [1:0]       out_size,
  input  logic             norm_en,
  output logic             sdout,
  output logic [SMP_W-1:0] left_smp,
  output logic [SMP_W-1:0] right_smp,
  output logic             smp_valid
);

  localparam int POS_W = $clog2(SLOT_BITS);

  logic             lock;
  logic [POS_W-1:0] pos;
  logic             lvl;

  sap_rx #(.SMP_W(SMP_W), .SLOT_BITS(SLOT_BITS)) u_rx (
    .bclk    (bclk),
    .rst_n   (rst_n),
    .lrck    (lrck),
    .sdin    (sdin),
    .fmt     (in_fmt),
    .size    (in_size),
    .lock    (lock),
    .pos     (pos),
    .lvl     (lvl),
    .left_o  (left_smp),
    .right_o (right_smp),
    .valid   (smp_valid)
  );

  sap_tx #(.SMP_W(SMP_W), .SLOT_BITS(SLOT_BITS)) u_tx (
    .bclk     (bclk),
    .rst_n    (rst_n),
    .lock     (lock),
    .pos      (pos),
    .lvl      (lvl),
    .left_i   (left_smp),
    .right_i  (right_smp),
    .in_fmt   (in_fmt),
    .out_fmt  (out_fmt),
    .out_size (out_size),
    .norm_en  (norm_en),
    .sdout    (sdout)
  );

endmodule

// File: tb/test_sap_reframer.sv
module test_sap_reframer;

  logic bclk = 1'b0;
  logic rst_n = 1'b0;
  logic lrck = 1'b0, sdin = 1'b0, norm_en = 1'b0;
  logic [1:0] in_fmt = 2'd0, in_size = 2'd2, out_fmt = 2'd0, out_size = 2'd2;
  logic sdout, smp_valid;
  logic [23:0] left_smp, right_smp;

  int vectors = 0;
  int fails = 0;

  logic [31:0] ob [0:12];
  logic        sl [0:12];
  logic [23:0] dl [0:5];
  logic [23:0] dr [0:5];
  logic [23:0] ol [0:7];
  logic [23:0] orr [0:7];

  always #5 bclk = ~bclk;

  sap_reframer i_sap_reframer (
    .bclk(bclk), .rst_n(rst_n), .lrck(lrck), .sdin(sdin),
    .in_fmt(in_fmt), .in_size(in_size), .out_fmt(out_fmt), .out_size(out_size),
    .norm_en(norm_en), .sdout(sdout), .left_smp(left_smp),
    .right_smp(right_smp), .smp_valid(smp_valid)
  );

  function automatic int wlen(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
  endfunction

  function automatic logic lleft(input logic [1:0] f);
    return (f == 2'd0) ? 1'b0 : 1'b1;
  endfunction

  function automatic int wstart(input logic [1:0] f, input int n);
    return (f == 2'd0) ? 1 : (f == 2'd2) ? 32 - n : 0;
  endfunction

  function automatic logic [23:0] topmask(input int n);
    return ~24'h0 << (24 - n);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] fi, input logic [1:0] si,
                          input logic [1:0] fo, input logic [1:0] so, input logic ne);
    @(negedge bclk);
    rst_n = 1'b0; in_fmt = fi; in_size = si; out_fmt = fo; out_size = so; norm_en = ne;
    lrck = ~lleft(fi); sdin = 1'b0;
    repeat (2) @(negedge bclk);
    rst_n = 1'b1;
  endtask

  // drives one idle slot and six frames, then checks capture and output
  task automatic run_stream(input logic [1:0] fi, input logic [1:0] si,
                            input logic [1:0] fo, input logic [1:0] so,
                            input logic ne, input int seed, input string req);
    int ni, no, sti, sto, vc, vbad, npair, j;
    logic [1:0] eff;
    logic [23:0] v, el, er, w;
    logic exp_v;
    ni = wlen(si); no = wlen(so); sti = wstart(fi, ni);
    eff = ne ? fo : fi; sto = wstart(eff, no);
    for (int k = 0; k < 6; k++) begin
      dl[k] = 24'(seed * 7919 + k * 24'h2B1C37) ^ 24'h8A5F13;
      dr[k] = 24'(seed * 104729 + k * 24'h51D3E9) ^ 24'h3C96A5;
    end
    do_reset(fi, si, fo, so, ne);
    vc = 0; vbad = 0;
    for (int g = 0; g < 13; g++) begin
      sl[g] = (g == 0) ? ~lleft(fi) : (((g - 1) % 2 == 0) ? lleft(fi) : ~lleft(fi));
      for (int p = 0; p < 32; p++) begin
        @(negedge bclk);
        lrck = sl[g];
        v = (g == 0) ? 24'h0 : (((g - 1) % 2 == 0) ? dl[(g - 1) / 2] : dr[(g - 1) / 2]);
        sdin = (g != 0 && p >= sti && p < sti + ni) ? v[23 - (p - sti)] : 1'b0;
        @(posedge bclk);
        #1;
        ob[g][p] = sdout;
        exp_v = (g != 0) && ((g - 1) % 2 == 1) && (p == sti + ni - 1);
        if (smp_valid !== exp_v) vbad++;
        if (smp_valid === 1'b1 && vc < 6) begin
          el = dl[vc] & topmask(ni);
          er = dr[vc] & topmask(ni);
          check(left_smp === el, {req, " R5"}, "left capture", left_smp, el);
          check(right_smp === er, {req, " R5"}, "right capture", right_smp, er);
          vc++;
        end
      end
    end
    check(vbad == 0, "R6", "valid strobe timing mismatches", 24'(vbad), 24'h0);
    check(vc == 6, "R6", "valid pulses per six frames", 24'(vc), 24'd6);
    check(ob[0] == 32'h0, "R7", "sdout before first LR edge", ob[0][23:0], 24'h0);
    npair = 0;
    for (int g = 1; g < 12; g++) begin
      if (sl[g] == lleft(eff) && npair < 8) begin
        w = 24'h0;
        for (int i = 0; i < no; i++) w = {w[22:0], ob[g][sto + i]};
        ol[npair] = w;
        w = 24'h0;
        for (int i = 0; i < no; i++) w = {w[22:0], ob[g + 1][sto + i]};
        orr[npair] = w;
        npair++;
      end
    end
    j = -1;
    el = (dl[1] & topmask(ni)) >> (24 - no);
    er = (dr[1] & topmask(ni)) >> (24 - no);
    for (int i = npair - 1; i >= 0; i--) if (ol[i] == el && orr[i] == er) j = i;
    check(j >= 0, ne ? "R8 R10" : "R9 R10", "frame 1 on sdout", (j >= 0) ? ol[j] : 24'hFFFFFF, el);
    for (int k = 2; k < 4; k++) begin
      el = (dl[k] & topmask(ni)) >> (24 - no);
      er = (dr[k] & topmask(ni)) >> (24 - no);
      if (j >= 0 && j + k - 1 < npair) begin
        check(ol[j + k - 1] == el, "R11", "next left on sdout", ol[j + k - 1], el);
        check(orr[j + k - 1] == er, "R11", "next right on sdout", orr[j + k - 1], er);
      end else begin
        check(1'b0, "R11", "output pair missing", 24'h0, el);
      end
    end
  endtask

  task automatic t_reset_state();
    do_reset(2'd0, 2'd2, 2'd0, 2'd2, 1'b0);
    rst_n = 1'b0;
    #2;
    check(smp_valid === 1'b0, "R1", "valid in reset", 24'(smp_valid), 24'h0);
    check(sdout === 1'b0, "R1", "sdout in reset", 24'(sdout), 24'h0);
    check(left_smp === 24'h0 && right_smp === 24'h0, "R1", "sample buses in reset", left_smp | right_smp, 24'h0);
    @(negedge bclk);
    rst_n = 1'b1;
    @(posedge bclk);
    #1;
    check(smp_valid === 1'b0 && left_smp === 24'h0, "R1", "state after release", left_smp, 24'h0);
  endtask

  task automatic t_unlocked_quiet();
    int bad;
    do_reset(2'd1, 2'd2, 2'd1, 2'd2, 1'b0);
    bad = 0;
    for (int c = 0; c < 80; c++) begin
      @(negedge bclk);
      lrck = 1'b1;
      sdin = c[0];
      @(posedge bclk);
      #1;
      if (smp_valid !== 1'b0 || sdout !== 1'b0) bad++;
    end
    check(bad == 0, "R7", "activity before LR transition", 24'(bad), 24'h0);
  endtask

  task automatic t_i2s_passthrough();
    run_stream(2'd0, 2'd2, 2'd1, 2'd2, 1'b0, 3, "R2 R9");
  endtask

  task automatic t_lj_to_i2s_pad();
    run_stream(2'd1, 2'd1, 2'd0, 2'd2, 1'b1, 5, "R3 R8 R10");
  endtask

  task automatic t_rj16_to_lj();
    run_stream(2'd2, 2'd0, 2'd1, 2'd0, 1'b1, 11, "R4 R8");
  endtask

  task automatic t_i2s_to_rj_trunc();
    run_stream(2'd0, 2'd2, 2'd2, 2'd0, 1'b1, 17, "R2 R8 R10");
  endtask

  task automatic t_norm_off_keeps_lj();
    run_stream(2'd1, 2'd2, 2'd2, 2'd1, 1'b0, 23, "R3 R9 R10");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_unlocked_quiet();
    t_i2s_passthrough();
    t_lj_to_i2s_pad();
    t_rj16_to_lj();
    t_i2s_to_rj_trunc();
    t_norm_off_keeps_lj();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule